// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block sits between a set of interrupt sources and a CPU core. It latches a rising edge on any source line as a pending request. Each source is given one of three service levels, or it is masked. A combinational priority scan then picks one winner among the pending, unmasked sources. The controller raises a single request line to the core and presents the winner's index and level as the vector.

Every request is gated by a global enable. The enable is not a separate control register. It is bit 0 of a model of the CPU flag word, which the block holds in full. Anything that reloads the flag word also moves the enable:

- a direct flag write,
- a flag restore on return from an interrupt handler,
- the enable and disable instruction strobes,
- the CPU acknowledge, which clears the enable so that a handler starts with interrupts off.

When the CPU acknowledges, the controller also retires the pending flag of the vectored source.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `flags_o` is all zero, `irq_req_o` is 0 and no source is pending. Setting the enable afterwards raises no request.
- R2: A 0-to-1 transition on `irq_src_i[i]` sets source i pending at that clock edge. A line held high after its request was retired does not set it pending again.
- R3: Source i's level is `src_prio_i[2i+1:2i]`, coded as follows: 2'b11 is high, 2'b10 is medium, 2'b01 is low and 2'b00 is masked. A masked source never drives the request or the vector.
- R4: The winner is a pending, unmasked source at the highest level present. Within a level, the lowest index wins. `irq_vec_o` gives the winner's index and `irq_lvl_o` gives its level code.
- R5: `irq_req_o` is 1 only when `flags_o[0]` is 1 and at least one unmasked source is pending.
- R6: An enable strobe (`ei_i`) sets `flags_o[0]` and a disable strobe (`di_i`) clears it. Both leave the other flag bits unchanged.
- R7: A flag write (`flag_we_i`) loads the whole of `flag_wdata_i` into `flags_o`. Bit 0 of the word becomes the enable.
- R8: A return restore (`ret_vld_i`) loads the whole of `ret_flags_i` into `flags_o`.
- R9: `ack_i` clears `flags_o[0]` and leaves the other flag bits as they were. If a winner exists, `ack_i` also clears that source's pending flag, unless a new rising edge on the same source arrives in that cycle, in which case the source stays pending.
- R10: When several flag updates arrive in one cycle, acknowledge beats return restore. Return restore beats flag write, flag write beats disable, and disable beats enable.
- R11: A masked source still latches its edge. It is requested and vectored once its level is raised above masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | NUM_SRC | Interrupt source lines, edge sensitive |
| src_prio_i | input | 2*NUM_SRC | Two-bit level code per source |
| ei_i | input | 1 | Enable-interrupt instruction strobe |
| di_i | input | 1 | Disable-interrupt instruction strobe |
| flag_we_i | input | 1 | Flag word write strobe |
| flag_wdata_i | input | FLAG_W | Flag word write data |
| ret_vld_i | input | 1 | Return-from-interrupt restore strobe |
| ret_flags_i | input | FLAG_W | Flag word popped on return |
| ack_i | input | 1 | CPU acknowledge of the request |
| irq_req_o | output | 1 | Request to the CPU |
| irq_vec_o | output | $clog2(NUM_SRC) | Index of the winning source |
| irq_lvl_o | output | 2 | Level code of the winning source |
| flags_o | output | FLAG_W | Current flag word, bit 0 is the global enable |

## Verification
The bench builds the block with the defaults, NUM_SRC = 8 and FLAG_W = 8. Eight sources are enough to place several at one level and others at every other level at once. This brings within reach the level ordering, the lowest-index tie-break inside a level and a masked source that is pending alongside enabled ones. The eight-bit flag word has upper bits that can be told apart from bit 0. This lets the bench show that strobes and the acknowledge touch only the enable, while writes and restores replace the whole word. It also lets the bench show which of several simultaneous updates wins.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MED  = 2'b10,
    LVL_HIGH = 2'b11
  } lvl_e;

  localparam int LVL_W = 2;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     src,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     rise,
  output logic [N-1:0]     pend
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src;
  end

  assign rise = src & ~src_q;

  for (genvar g = 0; g < N; g++) begin : g_pend
    // a fresh edge outranks a same-cycle retire
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   pend[g] <= 1'b0;
      else if (rise[g])                             pend[g] <= 1'b1;
      else if (clr_en && (clr_idx == IDX_W'(g)))    pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_ctrl_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]       pend,
  input  logic [2*N-1:0]     prio,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [LVL_W-1:0]   lvl
);
  localparam int RES_W = 1 + LVL_W + IDX_W;

  // result layout: {hit, level, index}
  function automatic logic [RES_W-1:0] scan(input logic [N-1:0] p,
                                            input logic [2*N-1:0] c);
    logic [RES_W-1:0] r;
    r = '0;
    for (int lv = 3; lv >= 1; lv--) begin
      for (int i = 0; i < N; i++) begin
        if (!r[RES_W-1] && p[i] && (c[2*i +: 2] == LVL_W'(lv)))
          r = {1'b1, LVL_W'(lv), IDX_W'(i)};
      end
    end
    return r;
  endfunction

  logic [RES_W-1:0] res;
  assign res   = scan(pend, prio);
  assign found = res[RES_W-1];
  assign lvl   = res[IDX_W +: LVL_W];
  assign idx   = res[IDX_W-1:0];
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack,
  input  logic          ret_vld,
  input  logic [FW-1:0] ret_flags,
  input  logic          we,
  input  logic [FW-1:0] wdata,
  input  logic          di,
  input  logic          ei,
  output logic [FW-1:0] flags
);
  localparam logic [FW-1:0] GIE_MASK = FW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (ack)     flags <= flags & ~GIE_MASK;
    else if (ret_vld) flags <= ret_flags;
    else if (we)      flags <= wdata;
    else if (di)      flags <= flags & ~GIE_MASK;
    else if (ei)      flags <= flags | GIE_MASK;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int FLAG_W  = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_src_i,
  input  logic [2*NUM_SRC-1:0] src_prio_i,
  input  logic                 ei_i,
  input  logic                 di_i,
  input  logic                 flag_we_i,
  input  logic [FLAG_W-1:0]    flag_wdata_i,
  input  logic                 ret_vld_i,
  input  logic [FLAG_W-1:0]    ret_flags_i,
  input  logic                 ack_i,
  output logic                 irq_req_o,
  output logic [IDX_W-1:0]     irq_vec_o,
  output logic [LVL_W-1:0]     irq_lvl_o,
  output logic [FLAG_W-1:0]    flags_o
);
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] pend_w;
  logic               found_w;
  logic [IDX_W-1:0]   win_idx_w;
  logic [LVL_W-1:0]   win_lvl_w;
  logic               retire_w;

  assign retire_w = ack_i & found_w;

  irq_edge_latch #(.N(NUM_SRC), .IDX_W(IDX_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (irq_src_i),
    .clr_en  (retire_w),
    .clr_idx (win_idx_w),
    .rise    (rise_w),
    .pend    (pend_w)
  );

  irq_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .pend  (pend_w),
    .prio  (src_prio_i),
    .found (found_w),
    .idx   (win_idx_w),
    .lvl   (win_lvl_w)
  );

  irq_flag_reg #(.FW(FLAG_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack_i),
    .ret_vld   (ret_vld_i),
    .ret_flags (ret_flags_i),
    .we        (flag_we_i),
    .wdata     (flag_wdata_i),
    .di        (di_i),
    .ei        (ei_i),
    .flags     (flags_o)
  );

  assign irq_req_o = flags_o[0] & found_w;
  assign irq_vec_o = win_idx_w;
  assign irq_lvl_o = win_lvl_w;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N     = 8,
  parameter int FW    = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     rise,
  input logic [2*N-1:0]   prio,
  input logic             found,
  input logic [FW-1:0]    flags,
  input logic             ack,
  input logic             ret_vld,
  input logic [FW-1:0]    ret_flags,
  input logic             we,
  input logic [FW-1:0]    wdata,
  input logic             di,
  input logic             ei,
  input logic             irq_req,
  input logic [IDX_W-1:0] vec,
  input logic [1:0]       lvl
);
  p_req_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flags[0] && found));

  p_winner_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend[vec] && (prio[2*vec +: 2] == lvl) && (lvl != 2'b00)));

  p_ack_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !flags[0]);

  p_ack_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && found && !rise[vec]) |=> !pend[$past(vec)]);

  p_ret_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !ack) |=> (flags == $past(ret_flags)));

  p_write_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !ret_vld && !ack) |=> (flags == $past(wdata)));

  p_di_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (di && !we && !ret_vld && !ack) |=> !flags[0]);

  p_ei_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ei && !di && !we && !ret_vld && !ack) |=> flags[0]);

  p_rise_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.N(NUM_SRC), .FW(FLAG_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend      (pend_w),
  .rise      (rise_w),
  .prio      (src_prio_i),
  .found     (found_w),
  .flags     (flags_o),
  .ack       (ack_i),
  .ret_vld   (ret_vld_i),
  .ret_flags (ret_flags_i),
  .we        (flag_we_i),
  .wdata     (flag_wdata_i),
  .di        (di_i),
  .ei        (ei_i),
  .irq_req   (irq_req_o),
  .vec       (irq_vec_o),
  .lvl       (irq_lvl_o)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int N  = 8;
  localparam int FW = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic [2*N-1:0] prio = '0;
  logic          ei = 0, di = 0, we = 0, rv = 0, ack = 0;
  logic [FW-1:0] wdat = '0, rdat = '0;
  logic          req;
  logic [IW-1:0] vec;
  logic [1:0]    lvl;
  logic [FW-1:0] flg;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .FLAG_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src), .src_prio_i(prio),
    .ei_i(ei), .di_i(di), .flag_we_i(we), .flag_wdata_i(wdat),
    .ret_vld_i(rv), .ret_flags_i(rdat), .ack_i(ack),
    .irq_req_o(req), .irq_vec_o(vec), .irq_lvl_o(lvl), .flags_o(flg)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic set_lvl(input int i, input logic [1:0] l);
    prio[2*i +: 2] = l;
  endtask

  task automatic pulse_ei();  ei = 1;  tick(); ei = 0;  endtask
  task automatic pulse_ack(); ack = 1; tick(); ack = 0; endtask

  // expect a request with the given index and level
  task automatic expect_win(input string rq, input int i, input int l);
    chk(req === 1'b1, rq, req, 1);
    chk(vec == IW'(i), rq, vec, i);
    chk(lvl == 2'(l), rq, lvl, l);
  endtask

  task automatic t_reset();
    chk(flg == '0, "R1", flg, 0);
    chk(req == 1'b0, "R1", req, 0);
    pulse_ei();
    chk(req == 1'b0, "R1", req, 0);
  endtask

  task automatic t_gate();
    we = 1; wdat = '0; tick(); we = 0;
    set_lvl(3, 2'b01);
    src[3] = 1; tick();
    chk(req == 1'b0, "R5", req, 0);
    pulse_ei();
    expect_win("R5", 3, 1);
    pulse_ack();
    chk(flg[0] == 1'b0, "R9", flg[0], 0);
    chk(req == 1'b0, "R9", req, 0);
    pulse_ei();
    chk(req == 1'b0, "R2", req, 0);
    src[3] = 0; tick();
  endtask

  task automatic t_priority();
    set_lvl(1, 2'b01); set_lvl(5, 2'b10); set_lvl(6, 2'b10);
    src[1] = 1; src[5] = 1; src[6] = 1; tick();
    expect_win("R4", 5, 2);
    pulse_ack(); pulse_ei();
    expect_win("R4", 6, 2);
    pulse_ack(); pulse_ei();
    expect_win("R4", 1, 1);
    pulse_ack(); pulse_ei();
    chk(req == 1'b0, "R4", req, 0);
    src = '0; tick();
    set_lvl(7, 2'b11); set_lvl(0, 2'b01);
    src[7] = 1; src[0] = 1; tick();
    expect_win("R3", 7, 3);
    pulse_ack(); pulse_ei();
    expect_win("R3", 0, 1);
    pulse_ack();
    src = '0; tick();
  endtask

  task automatic t_masked();
    set_lvl(4, 2'b00);
    pulse_ei();
    src[4] = 1; tick();
    chk(req == 1'b0, "R3", req, 0);
    set_lvl(4, 2'b11); tick();
    expect_win("R11", 4, 3);
    pulse_ack();
    src[4] = 0; tick();
  endtask

  task automatic t_ack_edge();
    set_lvl(2, 2'b01);
    pulse_ei();
    src[2] = 1; tick();
    expect_win("R9", 2, 1);
    src[2] = 0; tick();
    src[2] = 1; ack = 1; tick(); ack = 0;
    chk(flg[0] == 1'b0, "R9", flg[0], 0);
    pulse_ei();
    expect_win("R9", 2, 1);
    pulse_ack();
    src[2] = 0; tick();
  endtask

  task automatic t_flags();
    we = 1; wdat = 8'hA4; tick(); we = 0;
    chk(flg == 8'hA4, "R7", flg, 8'hA4);
    pulse_ei();
    chk(flg == 8'hA5, "R6", flg, 8'hA5);
    di = 1; tick(); di = 0;
    chk(flg == 8'hA4, "R6", flg, 8'hA4);
    we = 1; wdat = 8'h3B; tick(); we = 0;
    chk(flg == 8'h3B, "R7", flg, 8'h3B);
    rv = 1; rdat = 8'h81; tick(); rv = 0;
    chk(flg == 8'h81, "R8", flg, 8'h81);
    rv = 1; rdat = 8'h40; tick(); rv = 0;
    chk(flg == 8'h40, "R8", flg, 8'h40);
  endtask

  task automatic t_order();
    we = 1; wdat = 8'h01; tick(); we = 0;
    ei = 1; di = 1; tick(); ei = 0; di = 0;
    chk(flg == 8'h00, "R10", flg, 8'h00);
    we = 1; wdat = 8'h10; ei = 1; tick(); we = 0; ei = 0;
    chk(flg == 8'h10, "R10", flg, 8'h10);
    we = 1; wdat = 8'h11; di = 1; tick(); we = 0; di = 0;
    chk(flg == 8'h11, "R10", flg, 8'h11);
    rv = 1; rdat = 8'h20; we = 1; wdat = 8'h41; tick(); rv = 0; we = 0;
    chk(flg == 8'h20, "R10", flg, 8'h20);
    rv = 1; rdat = 8'h21; tick(); rv = 0;
    rv = 1; rdat = 8'h80; ack = 1; tick(); rv = 0; ack = 0;
    chk(flg == 8'h20, "R10", flg, 8'h20);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_gate();
    t_priority();
    t_masked();
    t_ack_edge();
    t_flags();
    t_order();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_up();
  end
endmodule